// File: doc/BRIEF.md
# DMA Transfer Length Calculator

This block works out how many bytes a data-transfer phase will move and tracks the byte counter that the host programs for it. The host writes a 16-bit counter one byte at a time, as a low byte and a middle byte, into a write-side shadow. A command whose top bit is set selects DMA mode and copies the shadow into the readable counter. A command with that bit clear selects programmed-I/O mode and leaves the readable counter alone.

When a transfer command arrives, the block takes the readable counter as it stands after that command's reload. A counter of zero stands for 65536 bytes. The block clips that count in one of two ways. While a command is being collected, the limit is 32 bytes. Otherwise the limit is the magnitude of a signed remaining-size value: a negative value means data flows toward the device and a positive value means data flows from it. The result is shown for one cycle on a strobe and then held.

The block also keeps the terminal-count status bit, the interrupt-cause byte and the size of the transfer in progress. It updates them when a counter is written, when a DMA transfer starts and when the DMA engine reports completion.

Top module: `dxl_top`

## Requirements
- R1: The transfer count is `{cnt_mid, cnt_lo}`, with the middle byte as the upper eight bits. A count of zero stands for 65536. `active_cnt` shows this count (17 bits) from the cycle after a transfer command, meaning a command whose low seven bits equal 0x10.
- R2: When `collect_mode` is high at the transfer command, `xfer_len` is the smaller of the count and 32.
- R3: When `collect_mode` is low, `xfer_len` is the smaller of the count and |`remain_size`|. This holds for a negative, a positive and a zero `remain_size`, including the most negative value.
- R4: A counter write updates the shadow byte: `cnt_wr_sel` = 0 selects the low byte and 1 selects the middle byte. The write clears `tc_flag` and leaves the readable `cnt_lo` and `cnt_mid` unchanged.
- R5: A command with bit 7 set sets `dma_mode` and copies both shadow bytes into `cnt_lo` and `cnt_mid`. A command with bit 7 clear clears `dma_mode` and keeps the readable bytes.
- R6: A transfer command with bit 7 set clears `tc_flag`. A transfer command with bit 7 clear leaves it unchanged.
- R7: A `dma_done` pulse sets `tc_flag`, sets `intr_cause` to 0x10 and clears `cnt_lo`, `cnt_mid` and `active_cnt`. The length register keeps its value.
- R8: `len_valid` is high for exactly the one cycle after a transfer command. `xfer_len` holds its value until the next transfer command.
- R9: After a synchronous reset, every output is zero.
- R10: A command that is not a transfer raises no strobe and leaves `xfer_len` and `active_cnt` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_wr_en | input | 1 | Host writes a counter byte |
| cnt_wr_sel | input | 1 | Selects the byte: 0 is low, 1 is middle |
| cnt_wr_data | input | 8 | Counter byte value |
| cmd_wr_en | input | 1 | Host writes a command |
| cmd_wr_data | input | 8 | Command: bit 7 selects DMA, bits 6:0 hold the opcode |
| remain_size | input | RSZ_W | Signed bytes remaining, negative toward the device |
| collect_mode | input | 1 | A command is being collected |
| dma_done | input | 1 | DMA completion pulse |
| len_valid | output | 1 | One-cycle strobe for a new length |
| xfer_len | output | 17 | Length of the transfer |
| active_cnt | output | 17 | Size of the transfer in progress, 0 when idle |
| cnt_lo | output | 8 | Readable low counter byte |
| cnt_mid | output | 8 | Readable middle counter byte |
| dma_mode | output | 1 | The last command selected DMA |
| tc_flag | output | 1 | Terminal-count status bit |
| intr_cause | output | 8 | Interrupt cause, 0x10 after completion |

## Verification
On every cycle, the assertions check the following:
- the length never exceeds the count, or the 32-byte cap during command collection;
- the strobe only follows a transfer command;
- the length holds between transfer commands;
- a counter write clears the terminal-count bit;
- a DMA-flagged command reloads the readable counter;
- completion puts the completion values in place.

Only the bench scenarios can show that the length equals the exact value the clipping rules call for. They also show that a zero counter becomes 65536, that a programmed-I/O transfer keeps the terminal-count bit, and that a non-transfer DMA command reloads the counter without raising a strobe.

// File: rtl/dxl_pkg.sv
package dxl_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int LEN_W  = CNT_W + 1;
    localparam int OP_W   = BYTE_W - 1;

    localparam logic [OP_W-1:0]   OP_XFER      = 7'h10;
    localparam logic [BYTE_W-1:0] INTR_BUS_SVC = 8'h10;
    localparam logic [LEN_W-1:0]  COLLECT_CAP  = 17'd32;

    typedef struct packed {
        logic [BYTE_W-1:0] mid;
        logic [BYTE_W-1:0] lo;
    } cnt_pair_t;

    typedef struct packed {
        logic            dma;
        logic [OP_W-1:0] op;
    } cmd_word_t;

    // Counter bytes to byte count; an all-zero counter means a full 2^CNT_W span
    function automatic logic [LEN_W-1:0] span_of(cnt_pair_t c);
        logic [CNT_W-1:0] raw;
        raw = {c.mid, c.lo};
        if (raw == '0)
            span_of = {1'b1, {CNT_W{1'b0}}};
        else
            span_of = {1'b0, raw};
    endfunction

    function automatic logic [LEN_W-1:0] min_len(logic [LEN_W-1:0] a, logic [LEN_W-1:0] b);
        min_len = (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/dxl_cnt_regs.sv
module dxl_cnt_regs
    import dxl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cnt_wr_en,
    input  logic              cnt_wr_sel,
    input  logic [BYTE_W-1:0] cnt_wr_data,
    input  logic              cmd_wr_en,
    input  cmd_word_t         cmd,
    input  logic              dma_done,
    output cnt_pair_t         live,
    output cnt_pair_t         live_next,
    output logic              dma_mode,
    output logic              tc,
    output logic [BYTE_W-1:0] intr
);

    cnt_pair_t shadow;
    logic      dma_start;

    assign dma_start = cmd_wr_en && cmd.dma && (cmd.op == OP_XFER);
    assign live_next = (cmd_wr_en && cmd.dma) ? shadow : live;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow   <= '0;
            live     <= '0;
            dma_mode <= 1'b0;
            tc       <= 1'b0;
            intr     <= '0;
        end else begin
            if (cnt_wr_en) begin
                if (cnt_wr_sel) shadow.mid <= cnt_wr_data;
                else            shadow.lo  <= cnt_wr_data;
            end
            if (dma_done) begin
                live <= '0;
                intr <= INTR_BUS_SVC;
            end
            if (cmd_wr_en) begin
                dma_mode <= cmd.dma;
                if (cmd.dma) live <= shadow;
            end
            if (dma_done)
                tc <= 1'b1;
            else if (cnt_wr_en || dma_start)
                tc <= 1'b0;
        end
    end

    // R4: counter write without completion leaves the terminal-count bit low
    p_tc_wr_clear_r4: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(cnt_wr_en && !dma_done) |-> !tc);

    // R4: a counter write alone never disturbs the readable bytes
    p_wr_keeps_live_r4: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(cnt_wr_en && !cmd_wr_en && !dma_done) |-> live == $past(live));

    // R5: a DMA-flagged command reloads the readable counter from the shadow
    p_reload_r5: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(cmd_wr_en && cmd.dma) |-> live == $past(shadow) && dma_mode);

    // R6: a DMA transfer start leaves terminal count low
    p_start_clear_r6: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(dma_start && !dma_done) |-> !tc);

    // R7: completion values
    p_done_r7: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(dma_done && !cmd_wr_en) |-> tc && live == '0 && intr == INTR_BUS_SVC);

endmodule

// File: rtl/dxl_len_calc.sv
module dxl_len_calc
    import dxl_pkg::*;
#(
    parameter int RSZ_W = 24
) (
    input  logic [LEN_W-1:0]        span,
    input  logic signed [RSZ_W-1:0] remain,
    input  logic                    collect,
    output logic [LEN_W-1:0]        len
);

    localparam int CMP_W = (RSZ_W > LEN_W) ? RSZ_W : LEN_W;

    logic [RSZ_W-1:0] mag;
    logic [CMP_W-1:0] mag_w;
    logic [CMP_W-1:0] span_w;
    logic [LEN_W-1:0] size_clip;

    // Unsigned magnitude; the most negative value still fits in RSZ_W bits
    assign mag    = remain[RSZ_W-1] ? (~remain + 1'b1) : remain;
    assign mag_w  = CMP_W'(mag);
    assign span_w = CMP_W'(span);

    generate
        if (RSZ_W > LEN_W) begin : g_wide_remain
            assign size_clip = (mag_w < span_w) ? LEN_W'(mag_w) : span;
        end else begin : g_narrow_remain
            assign size_clip = min_len(span, LEN_W'(mag));
        end
    endgenerate

    assign len = collect ? min_len(span, COLLECT_CAP) : size_clip;

endmodule

// File: rtl/dxl_len_track.sv
module dxl_len_track
    import dxl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [LEN_W-1:0] len_in,
    input  logic [LEN_W-1:0] span_in,
    input  logic             done,
    output logic             len_valid,
    output logic [LEN_W-1:0] xfer_len,
    output logic [LEN_W-1:0] active_cnt
);

    always_ff @(posedge clk) begin
        if (rst) begin
            len_valid  <= 1'b0;
            xfer_len   <= '0;
            active_cnt <= '0;
        end else begin
            len_valid <= start;
            if (start) begin
                xfer_len   <= len_in;
                active_cnt <= span_in;
            end else if (done) begin
                active_cnt <= '0;
            end
        end
    end

    // R8: strobe only in the cycle after a transfer command
    p_strobe_cause_r8: assert property (@(posedge clk) disable iff (rst)
        len_valid |-> !$past(rst) && $past(start));

    // R8: length holds between transfer commands
    p_len_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && !$past(start) |-> $stable(xfer_len));

    // R3: the length never exceeds the count it was drawn from
    p_len_bound_r3: assert property (@(posedge clk) disable iff (rst)
        len_valid |-> xfer_len <= active_cnt);

    // R7: completion without a new start leaves no transfer active
    p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(done && !start) |-> active_cnt == '0);

endmodule

// File: rtl/dxl_top.sv
module dxl_top
    import dxl_pkg::*;
#(
    parameter int RSZ_W = 24
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cnt_wr_en,
    input  logic                    cnt_wr_sel,
    input  logic [7:0]              cnt_wr_data,
    input  logic                    cmd_wr_en,
    input  logic [7:0]              cmd_wr_data,
    input  logic signed [RSZ_W-1:0] remain_size,
    input  logic                    collect_mode,
    input  logic                    dma_done,
    output logic                    len_valid,
    output logic [16:0]             xfer_len,
    output logic [16:0]             active_cnt,
    output logic [7:0]              cnt_lo,
    output logic [7:0]              cnt_mid,
    output logic                    dma_mode,
    output logic                    tc_flag,
    output logic [7:0]              intr_cause
);

    cmd_word_t        cmd;
    cnt_pair_t        live;
    cnt_pair_t        live_next;
    logic             xfer_cmd;
    logic [LEN_W-1:0] span;
    logic [LEN_W-1:0] len_calc;

    assign cmd      = cmd_word_t'(cmd_wr_data);
    assign xfer_cmd = cmd_wr_en && (cmd.op == OP_XFER);
    assign span     = span_of(live_next);

    dxl_cnt_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .cnt_wr_en   (cnt_wr_en),
        .cnt_wr_sel  (cnt_wr_sel),
        .cnt_wr_data (cnt_wr_data),
        .cmd_wr_en   (cmd_wr_en),
        .cmd         (cmd),
        .dma_done    (dma_done),
        .live        (live),
        .live_next   (live_next),
        .dma_mode    (dma_mode),
        .tc          (tc_flag),
        .intr        (intr_cause)
    );

    dxl_len_calc #(.RSZ_W(RSZ_W)) u_calc (
        .span    (span),
        .remain  (remain_size),
        .collect (collect_mode),
        .len     (len_calc)
    );

    dxl_len_track u_track (
        .clk        (clk),
        .rst        (rst),
        .start      (xfer_cmd),
        .len_in     (len_calc),
        .span_in    (span),
        .done       (dma_done),
        .len_valid  (len_valid),
        .xfer_len   (xfer_len),
        .active_cnt (active_cnt)
    );

    assign cnt_lo  = live.lo;
    assign cnt_mid = live.mid;

    // R2: collection caps the length at 32
    p_collect_cap_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(xfer_cmd && collect_mode) |-> xfer_len <= COLLECT_CAP);

    // R10: a non-transfer command raises no strobe
    p_no_strobe_r10: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(cmd_wr_en && !xfer_cmd) |-> !len_valid);

endmodule

// File: tb/dxl_top_bench.sv
module dxl_top_bench;

    localparam int RSZ_W = 24;

    typedef struct packed {
        logic [7:0]              lo;
        logic [7:0]              mid;
        logic signed [RSZ_W-1:0] rem;
        logic                    col;
        logic [16:0]             len;
        logic [16:0]             span;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{8'h40, 8'h00,  24'sd100,     1'b0, 17'd64,    17'd64},
        '{8'h00, 8'h01,  24'sd100,     1'b0, 17'd100,   17'd256},
        '{8'h00, 8'h00,  24'sd70000,   1'b0, 17'd65536, 17'd65536},
        '{8'h00, 8'h00, -24'sd300,     1'b0, 17'd300,   17'd65536},
        '{8'h20, 8'h03, -24'sd2000,    1'b0, 17'd800,   17'd800},
        '{8'h50, 8'h00,  24'sd5,       1'b1, 17'd32,    17'd80},
        '{8'h10, 8'h00,  24'sd5,       1'b1, 17'd16,    17'd16},
        '{8'h34, 8'h12,  24'sd0,       1'b0, 17'd0,     17'd4660},
        '{8'hff, 8'hff, -24'sd8388608, 1'b0, 17'd65535, 17'd65535}
    };

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    cnt_wr_en = 1'b0;
    logic                    cnt_wr_sel = 1'b0;
    logic [7:0]              cnt_wr_data = '0;
    logic                    cmd_wr_en = 1'b0;
    logic [7:0]              cmd_wr_data = '0;
    logic signed [RSZ_W-1:0] remain_size = '0;
    logic                    collect_mode = 1'b0;
    logic                    dma_done = 1'b0;
    logic                    len_valid;
    logic [16:0]             xfer_len;
    logic [16:0]             active_cnt;
    logic [7:0]              cnt_lo;
    logic [7:0]              cnt_mid;
    logic                    dma_mode;
    logic                    tc_flag;
    logic [7:0]              intr_cause;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    dxl_top #(.RSZ_W(RSZ_W)) u_dxl_top (
        .clk(clk), .rst(rst),
        .cnt_wr_en(cnt_wr_en), .cnt_wr_sel(cnt_wr_sel), .cnt_wr_data(cnt_wr_data),
        .cmd_wr_en(cmd_wr_en), .cmd_wr_data(cmd_wr_data),
        .remain_size(remain_size), .collect_mode(collect_mode), .dma_done(dma_done),
        .len_valid(len_valid), .xfer_len(xfer_len), .active_cnt(active_cnt),
        .cnt_lo(cnt_lo), .cnt_mid(cnt_mid), .dma_mode(dma_mode),
        .tc_flag(tc_flag), .intr_cause(intr_cause)
    );

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    // Inputs change 1 ns after a rising edge; outputs are read at the same point
    task automatic step();
        @(posedge clk);
        #1;
        cnt_wr_en = 1'b0;
        cmd_wr_en = 1'b0;
        dma_done  = 1'b0;
    endtask

    task automatic wr_cnt(input logic sel, input logic [7:0] d);
        cnt_wr_en = 1'b1; cnt_wr_sel = sel; cnt_wr_data = d;
        step();
    endtask

    task automatic wr_cmd(input logic [7:0] c);
        cmd_wr_en = 1'b1; cmd_wr_data = c;
        step();
    endtask

    task automatic pulse_done();
        dma_done = 1'b1;
        step();
    endtask

    initial begin
        repeat (10000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        // R9: reset state
        chk("R9", "len_valid", 32'(len_valid), 0);
        chk("R9", "xfer_len", 32'(xfer_len), 0);
        chk("R9", "active_cnt", 32'(active_cnt), 0);
        chk("R9", "cnt", {16'h0, cnt_mid, cnt_lo}, 0);
        chk("R9", "dma_mode/tc", {30'h0, dma_mode, tc_flag}, 0);
        chk("R9", "intr_cause", 32'(intr_cause), 0);

        for (int i = 0; i < NV; i++) begin
            wr_cnt(1'b0, VECS[i].lo);
            wr_cnt(1'b1, VECS[i].mid);
            remain_size  = VECS[i].rem;
            collect_mode = VECS[i].col;
            wr_cmd(8'h90);
            // R1 R2 R3 R5 R6 R8 at the edge after the command
            chk("R8", "len_valid", 32'(len_valid), 1);
            chk(VECS[i].col ? "R2" : "R3", "xfer_len", 32'(xfer_len), 32'(VECS[i].len));
            chk("R1", "active_cnt", 32'(active_cnt), 32'(VECS[i].span));
            chk("R5", "cnt reload", {16'h0, cnt_mid, cnt_lo}, {16'h0, VECS[i].mid, VECS[i].lo});
            chk("R6", "tc after dma start", 32'(tc_flag), 0);
            step();
            chk("R8", "strobe one cycle", 32'(len_valid), 0);
            chk("R8", "len held", 32'(xfer_len), 32'(VECS[i].len));
            pulse_done();
            // R7: completion
            chk("R7", "tc", 32'(tc_flag), 1);
            chk("R7", "intr_cause", 32'(intr_cause), 32'h10);
            chk("R7", "cnt cleared", {16'h0, cnt_mid, cnt_lo}, 0);
            chk("R7", "active cleared", 32'(active_cnt), 0);
            chk("R7", "len kept", 32'(xfer_len), 32'(VECS[i].len));
        end

        // R4: counter write clears tc and leaves readable bytes alone
        wr_cnt(1'b0, 8'h22);
        chk("R4", "tc cleared", 32'(tc_flag), 0);
        chk("R4", "readable kept", {16'h0, cnt_mid, cnt_lo}, 0);
        wr_cnt(1'b1, 8'h00);
        pulse_done();
        chk("R7", "tc set again", 32'(tc_flag), 1);

        // R5 R6: PIO transfer uses the readable zero counter, keeps tc
        remain_size  = 24'sd9;
        collect_mode = 1'b0;
        wr_cmd(8'h10);
        chk("R5", "pio mode", 32'(dma_mode), 0);
        chk("R5", "pio no reload", {16'h0, cnt_mid, cnt_lo}, 0);
        chk("R6", "pio tc kept", 32'(tc_flag), 1);
        chk("R1", "zero count span", 32'(active_cnt), 32'd65536);
        chk("R3", "pio len", 32'(xfer_len), 9);

        // R10: non-transfer commands
        wr_cmd(8'h01);
        chk("R10", "no strobe", 32'(len_valid), 0);
        chk("R10", "len held", 32'(xfer_len), 9);
        wr_cmd(8'h80);
        chk("R10", "no strobe dma", 32'(len_valid), 0);
        chk("R10", "active held", 32'(active_cnt), 32'd65536);
        chk("R5", "dma reload", {16'h0, cnt_mid, cnt_lo}, 32'h0022);
        chk("R5", "dma mode", 32'(dma_mode), 1);
        chk("R6", "non-transfer keeps tc", 32'(tc_flag), 1);

        // R6: DMA transfer clears tc
        wr_cmd(8'h90);
        chk("R6", "dma start clears tc", 32'(tc_flag), 0);
        chk("R3", "len from reload", 32'(xfer_len), 9);

        // R9: reset mid-run
        rst = 1'b1;
        step();
        rst = 1'b0;
        chk("R9", "reset again", {13'h0, len_valid, dma_mode, tc_flag, intr_cause, cnt_lo}, 0);
        chk("R9", "reset len", 32'(xfer_len), 0);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule